// File: doc/BRIEF.md
# One-Wire Search Triplet Sequencer

This block carries out a single branch step of the one-wire device search. After a start strobe it asks a bit-slot engine for two read slots. The first returns the current ID bit of every device still taking part, wired-AND. The second returns the complement of that bit. From this pair the block picks a branch direction and asks for one write slot that sends the chosen direction onto the bus. The devices that do not match that direction then drop out of the search.

A preferred direction comes in with the start strobe and is held for the whole step. It decides the branch only when the two reads disagree with each other's complement, which means both values of the bit are present on the bus. If only one value is present, that value is taken. If neither read pulls the line low, no device answered, so the step reports an error and sends no write slot. The step ends with a one-cycle done pulse and a 3-bit result code. The caller keeps the 64-bit search state between steps.

Top module: `owire_triplet_seq`

## Requirements
- R1: After synchronous reset, `slot_req`, `done` and `busy` are 0 and `result` is 3'b000.
- R2: A `start` taken while idle raises `slot_req` on the next clock edge. The first two slots are read slots, with `slot_wr` = 1. The `slot_rd` value returned with the first acknowledge is taken as the ID bit, and the value returned with the second acknowledge is taken as the complement bit.
- R3: While `slot_req` is high and `slot_ack` is low, `slot_req` stays high and `slot_wr` does not change.
- R4: If the ID bit and the complement bit are both 1, no third slot is requested and `result` = 3'b011.
- R5: If both bits are 0, a write slot is requested with `slot_wr` equal to the preferred direction, and `result` = {direction, 0, 0}. This gives 3'b100 for direction 1 and 3'b000 for direction 0.
- R6: If exactly one bit is 1, the direction is the ID bit and it is written. `result` is 3'b101 when the ID bit is 1 and 3'b010 when it is 0. The result fields are: bit 0 the ID bit, bit 1 the complement bit, bit 2 the direction.
- R7: `dir_pref` is sampled with `start`. Changes to it during a step have no effect.
- R8: `done` is high for exactly the one cycle that follows the clock edge that takes the final slot's acknowledge. `result` changes only in that cycle and then holds until the next step's done.
- R9: A `start` during a step is ignored. The step still issues its normal slots, and no further slot is requested after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one search step |
| dir_pref | input | 1 | Direction to take when both bit values are present |
| slot_req | output | 1 | Request to the bit-slot engine, held until acknowledged |
| slot_wr | output | 1 | Slot type: 1 = read slot (write-1), 0 = write-0 slot |
| slot_ack | input | 1 | One-cycle slot completion from the engine |
| slot_rd | input | 1 | Bus value sampled in the slot, valid with `slot_ack` |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle end-of-step pulse |
| result | output | 3 | {direction, complement bit, ID bit}; 3'b011 means no device answered |

## Verification
A bad latch of the ID or complement bit shows up at the end of the step. It appears as a wrong `result` in the done cycle, or as a wrong `slot_wr` on the third request one cycle after the second acknowledge. If the sequencer jumps to the wrong state, the slot count at the engine is wrong: an error step that still writes, or a valid step that ends after two slots. The bench sees this on the cycle after the second acknowledge. A bad direction latch or a missed busy guard shows on the write slot or as extra requests right after `done`.

// File: rtl/owt_pkg.sv
package owt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ID,
        ST_RD_CMP,
        ST_WR,
        ST_FIN
    } step_state_t;

    // Field order matters: bit 0 id, bit 1 complement, bit 2 direction.
    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } step_res_t;

    typedef struct packed {
        logic err;
        logic dir;
    } branch_t;

    localparam int RES_W = $bits(step_res_t);
    localparam step_res_t RES_NONE = '{dir: 1'b0, cmp: 1'b1, id: 1'b1};
    localparam step_res_t RES_ZERO = '{dir: 1'b0, cmp: 1'b0, id: 1'b0};

    function automatic branch_t pick_branch(input logic id, input logic cmp,
                                            input logic pref);
        branch_t b;
        b.err = id & cmp;
        b.dir = (id ^ cmp) ? id : pref;
        return b;
    endfunction

endpackage

// File: rtl/owt_branch.sv
module owt_branch
    import owt_pkg::*;
(
    input  logic    id_bit,
    input  logic    cmp_bit,
    input  logic    pref,
    output branch_t choice
);
    always_comb begin
        choice = pick_branch(id_bit, cmp_bit, pref);
    end
endmodule

// File: rtl/owt_seq.sv
module owt_seq
    import owt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      dir_pref,
    input  logic      slot_ack,
    input  logic      slot_rd,
    input  branch_t   choice,
    output logic      id_q,
    output logic      pref_q,
    output logic      slot_req,
    output logic      slot_wr,
    output logic      busy,
    output logic      done,
    output step_res_t result
);
    step_state_t state;
    logic        cmp_q;
    logic        dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            id_q   <= 1'b0;
            cmp_q  <= 1'b0;
            dir_q  <= 1'b0;
            pref_q <= 1'b0;
            result <= RES_ZERO;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    pref_q <= dir_pref;
                    state  <= ST_RD_ID;
                end
                ST_RD_ID: if (slot_ack) begin
                    id_q  <= slot_rd;
                    state <= ST_RD_CMP;
                end
                ST_RD_CMP: if (slot_ack) begin
                    cmp_q <= slot_rd;
                    dir_q <= choice.dir;
                    if (choice.err) begin
                        result <= RES_NONE;
                        state  <= ST_FIN;
                    end else begin
                        state <= ST_WR;
                    end
                end
                ST_WR: if (slot_ack) begin
                    result <= '{dir: dir_q, cmp: cmp_q, id: id_q};
                    state  <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        slot_req = (state == ST_RD_ID) || (state == ST_RD_CMP) || (state == ST_WR);
        slot_wr  = (state == ST_WR) ? dir_q : 1'b1;
        busy     = (state != ST_IDLE);
        done     = (state == ST_FIN);
    end

    // R1: idle keeps the engine interface quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!slot_req && !done));

    // R3: a pending request and its slot type hold until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (slot_req && !slot_ack) |=> (slot_req && $stable(slot_wr)));

    // R4: an all-ones pair ends the step without a write slot
    p_err_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_CMP && slot_ack && slot_rd && id_q) |=> (!slot_req && done));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: result only moves in the done cycle
    p_res_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R9: a start while busy does not restart the step
    p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (slot_req && !slot_ack && start) |=> (slot_req && !done));

endmodule

// File: rtl/owire_triplet_seq.sv
module owire_triplet_seq
    import owt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir_pref,
    output logic             slot_req,
    output logic             slot_wr,
    input  logic             slot_ack,
    input  logic             slot_rd,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    branch_t   choice;
    logic      id_q;
    logic      pref_q;
    step_res_t res_s;

    // The complement bit is decided from the live bus value in its ack cycle.
    owt_branch u_branch (
        .id_bit  (id_q),
        .cmp_bit (slot_rd),
        .pref    (pref_q),
        .choice  (choice)
    );

    owt_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dir_pref (dir_pref),
        .slot_ack (slot_ack),
        .slot_rd  (slot_rd),
        .choice   (choice),
        .id_q     (id_q),
        .pref_q   (pref_q),
        .slot_req (slot_req),
        .slot_wr  (slot_wr),
        .busy     (busy),
        .done     (done),
        .result   (res_s)
    );

    assign result = res_s;
endmodule

// File: tb/owire_triplet_seq_bench.sv
module owire_triplet_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       dir_pref = 1'b0;
    logic       slot_ack = 1'b0;
    logic       slot_rd = 1'b0;
    logic       slot_req;
    logic       slot_wr;
    logic       busy;
    logic       done;
    logic [2:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    owire_triplet_seq u_owire_triplet_seq (
        .clk(clk), .rst(rst), .start(start), .dir_pref(dir_pref),
        .slot_req(slot_req), .slot_wr(slot_wr), .slot_ack(slot_ack),
        .slot_rd(slot_rd), .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(slot_req == 0, "R1 slot_req", slot_req, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(result == 3'b000, "R1 result", result, 0);
    endtask

    // One full step with a modelled slot engine.
    task automatic t_step(input bit dir, input bit id, input bit cmp,
                          input int gap, input bit poke_start, input bit flip_dir);
        bit       err;
        bit       dirx;
        int       nslots;
        logic [2:0] exp_res;
        logic [2:0] prev_res;
        logic       wr_seen;
        err     = id & cmp;
        dirx    = (id ^ cmp) ? id : dir;
        nslots  = err ? 2 : 3;
        exp_res = err ? 3'b011 : {dirx, cmp, id};
        prev_res = result;

        @(negedge clk);
        start = 1'b1;
        dir_pref = dir;
        @(negedge clk);
        start = 1'b0;
        chk(slot_req == 1, "R2 request after start", slot_req, 1);
        chk(busy == 1, "R2 busy after start", busy, 1);

        for (int s = 0; s < nslots; s++) begin
            chk(slot_req == 1, "R2 slot requested", slot_req, 1);
            if (s < 2)
                chk(slot_wr == 1, "R2 read slot type", slot_wr, 1);
            else if (id ^ cmp)
                chk(slot_wr == dirx, "R6 forced direction written", slot_wr, dirx);
            else
                chk(slot_wr == dirx, "R5 preferred direction written", slot_wr, dirx);
            wr_seen = slot_wr;
            if (flip_dir) dir_pref = ~dir;
            if (poke_start) start = 1'b1;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                start = 1'b0;
                chk(slot_req == 1 && slot_wr == wr_seen, "R3 request held",
                    {slot_req, slot_wr}, {1'b1, wr_seen});
                chk(done == 0, "R9 no early done", done, 0);
            end
            chk(result == prev_res, "R8 result held mid-step", result, prev_res);
            slot_rd  = (s == 0) ? id : (s == 1) ? cmp : 1'b0;
            slot_ack = 1'b1;
            @(negedge clk);
            slot_ack = 1'b0;
            start    = 1'b0;
            if (s < nslots - 1)
                chk(done == 0, "R8 done not before final slot", done, 0);
        end

        chk(done == 1, "R8 done after final ack", done, 1);
        chk(slot_req == 0, err ? "R4 no write slot" : "R8 no request at done", slot_req, 0);
        if (err)
            chk(result == exp_res, "R4 error code", result, exp_res);
        else if (id ^ cmp)
            chk(result == exp_res, "R6 single-value code", result, exp_res);
        else
            chk(result == exp_res, flip_dir ? "R7 latched direction code" : "R5 both-present code",
                result, exp_res);
        @(negedge clk);
        chk(done == 0, "R8 done one cycle", done, 0);
        chk(result == exp_res, "R8 result stays", result, exp_res);
        for (int k = 0; k < 4; k++) begin
            chk(slot_req == 0 && busy == 0, "R9 no extra step", {slot_req, busy}, 0);
            @(negedge clk);
        end
        chk(result == exp_res, "R8 result stable idle", result, exp_res);
    endtask

    initial begin
        t_reset();
        t_step(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);   // 000
        t_step(1'b1, 1'b0, 1'b0, 2, 1'b0, 1'b0);   // 100
        t_step(1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b0);   // 101
        t_step(1'b1, 1'b0, 1'b1, 3, 1'b0, 1'b0);   // 010
        t_step(1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0);   // 011
        t_step(1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0);   // 011, pref ignored
        t_step(1'b1, 1'b0, 1'b0, 2, 1'b0, 1'b1);   // R7 dir change mid-step
        t_step(1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b1);   // R7 other polarity
        t_step(1'b1, 1'b1, 1'b0, 2, 1'b1, 1'b0);   // R9 start while busy
        t_step(1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b0);   // R9 on error path
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule